// File: doc/BRIEF.md
# Synchronous Bit-Stuffing Frame Receiver

This block receives a serial bit stream in which frames are bounded by flag octets and made transparent by zero insertion. One line bit arrives with each clock on which `bit_en` is high. The receiver looks for the flag pattern at all times. It removes the transparency zeros and delivers the recovered frame content two ways: one bit at a time with a valid strobe, and as assembled octets with a separate strobe. At the end of each frame it reports one outcome: a good end, a runt or an abort. A good end can also carry a misalignment indication.

Content is delayed by exactly eight accepted line bits. This lets the block recognise the closing flag before any of its bits could be passed on as content. A downstream consumer watches `out_sof` to start a new frame and treats `frame_runt` or `frame_abort` as an instruction to drop whatever it has collected since then. Checking the frame check sequence and decoding fields belong to later stages.

Top module: `hdlc_deframer`

## Requirements
- R1: After reset every output is 0, and the receiver is hunting for a flag. Line bits that arrive before the first flag produce no output of any kind.
- R2: The flag is the line pattern 0,1,1,1,1,1,1,0 in arrival order and is recognised wherever it occurs. After an opening flag, each content bit appears on `out_bit` with `out_valid` high for one clock. This happens one clock after the edge that accepts the eighth later line bit. Cycles with `bit_en` low are ignored.
- R3: Inside a frame, a 0 that arrives directly after five contiguous 1s is removed. It is never presented and is not counted toward the frame length or octet assembly.
- R4: `out_sof` is high together with `out_valid` for the first content bit of each frame, and only for that bit.
- R5: Content bits are packed least significant bit first: the earliest bit of a group lands in `octet_data[0]`. `octet_valid` is high in the same cycle as the eighth bit of each group, and is otherwise 0 along with `octet_data`. Grouping restarts at every flag and abort.
- R6: A closing flag with at least MIN_BITS (default 32) content bits gives a one-clock `frame_end` pulse. The pulse comes one clock after the edge that accepts the flag's final 0. The same flag opens the next frame.
- R7: A closing flag with 1 to MIN_BITS-1 content bits gives `frame_runt` in place of `frame_end`.
- R8: Two flags with no content between them give no strobe at all.
- R9: Seven contiguous 1s inside a frame give a one-clock `frame_abort` pulse. No content bit is presented in that cycle. The receiver then goes back to hunting and ignores everything until the next flag. Seven or more 1s while hunting give no abort.
- R10: `frame_misaligned` is high together with `frame_end` when the content length is not a multiple of 8, and is 0 otherwise.
- R11: At most one of `frame_end`, `frame_runt` and `frame_abort` is high in any cycle. Every output is 0 in a cycle that does not follow an accepted line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit qualifier, one bit accepted per high cycle |
| bit_in | input | 1 | Serial line bit |
| out_bit | output | 1 | Recovered content bit (0 when not valid) |
| out_valid | output | 1 | Content bit strobe |
| out_sof | output | 1 | First content bit of a frame |
| octet_data | output | 8 | Assembled octet, bit 0 received first |
| octet_valid | output | 1 | Octet strobe |
| frame_end | output | 1 | Frame closed with enough content |
| frame_runt | output | 1 | Frame closed too short |
| frame_abort | output | 1 | Frame aborted by a run of seven 1s |
| frame_misaligned | output | 1 | With frame_end: length not octet-aligned |

## Verification
The assertions assume that `rst` is held for at least one clock edge before operation. They also assume that `bit_in` matters only when `bit_en` is high, so a strobe must trace back to a cycle with `bit_en` high. The bench builds its line stream with a behavioural transmitter that inserts a zero after every run of five 1s and sends flags unstuffed. An abort is made on purpose by sending raw 1s. The bench regularly inserts cycles with `bit_en` low and a misleading `bit_in` value, which exercises the rule that unqualified cycles are ignored.

// File: rtl/hdlc_dfr_pkg.sv
package hdlc_dfr_pkg;

    localparam int FLAG_LEN  = 8;
    localparam int STUFF_RUN = 5;
    localparam int FLAG_RUN  = 6;
    localparam int ABORT_RUN = 7;
    localparam int OCTET_W   = 8;
    localparam int RUN_W     = $clog2(ABORT_RUN + 1);

    // What a single accepted line bit means, judged by the run of 1s before it
    typedef enum logic [1:0] {
        EV_DATA  = 2'd0,
        EV_STUFF = 2'd1,
        EV_FLAG  = 2'd2,
        EV_ABORT = 2'd3
    } line_ev_e;

    // One position of the lookahead line
    typedef struct packed {
        logic keep;
        logic val;
    } slot_t;

    function automatic line_ev_e classify(input logic [RUN_W-1:0] run, input logic b);
        if (b) begin
            if (run == RUN_W'(FLAG_RUN)) return EV_ABORT;
            return EV_DATA;
        end
        if (run == RUN_W'(FLAG_RUN))  return EV_FLAG;
        if (run == RUN_W'(STUFF_RUN)) return EV_STUFF;
        return EV_DATA;
    endfunction

    function automatic logic [RUN_W-1:0] next_run(input logic [RUN_W-1:0] run, input logic b);
        if (!b) return '0;
        if (run == RUN_W'(ABORT_RUN)) return run;
        return run + RUN_W'(1);
    endfunction

endpackage

// File: rtl/hdlc_run_tracker.sv
module hdlc_run_tracker
    import hdlc_dfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_e ev
);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bit_en) begin
            run_q <= next_run(run_q, bit_in);
        end
    end

    always_comb begin
        ev = classify(run_q, bit_in);
    end

    // R9
    abort_run_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && ev == EV_ABORT) |=> (run_q == RUN_W'(ABORT_RUN)));

endmodule

// File: rtl/hdlc_slot_line.sv
module hdlc_slot_line
    import hdlc_dfr_pkg::*;
#(
    parameter int DEPTH = FLAG_LEN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  logic  flush,
    input  slot_t din,
    output slot_t dout
);

    logic [DEPTH-1:0] vals_q;
    logic [DEPTH-1:0] keeps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vals_q  <= '0;
            keeps_q <= '0;
        end else if (shift) begin
            if (flush) begin
                vals_q  <= '0;
                keeps_q <= '0;
            end else begin
                vals_q  <= {vals_q[DEPTH-2:0], din.val};
                keeps_q <= {keeps_q[DEPTH-2:0], din.keep};
            end
        end
    end

    always_comb begin
        dout.val  = vals_q[DEPTH-1];
        dout.keep = keeps_q[DEPTH-1];
    end

endmodule

// File: rtl/hdlc_frame_tracker.sv
module hdlc_frame_tracker
    import hdlc_dfr_pkg::*;
#(
    parameter int MIN_BITS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  line_ev_e           ev,
    input  slot_t              exit_s,
    output logic               in_frame,
    output logic               out_bit,
    output logic               out_valid,
    output logic               out_sof,
    output logic [OCTET_W-1:0] octet_data,
    output logic               octet_valid,
    output logic               frame_end,
    output logic               frame_runt,
    output logic               frame_abort,
    output logic               frame_misaligned
);

    localparam int CNT_W = $clog2(MIN_BITS + 1);
    localparam int POS_W = $clog2(OCTET_W);

    logic [CNT_W-1:0]   cnt_q, cnt_inc;
    logic [POS_W-1:0]   pos_q, pos_inc;
    logic [OCTET_W-1:0] sh_q, sh_next;
    logic               emit;

    always_comb begin
        emit    = exit_s.keep && (ev != EV_ABORT);
        cnt_inc = cnt_q;
        if (emit && cnt_q != CNT_W'(MIN_BITS)) cnt_inc = cnt_q + CNT_W'(1);
        pos_inc = emit ? pos_q + POS_W'(1) : pos_q;
        sh_next = {exit_s.val, sh_q[OCTET_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame         <= 1'b0;
            cnt_q            <= '0;
            pos_q            <= '0;
            sh_q             <= '0;
            out_bit          <= 1'b0;
            out_valid        <= 1'b0;
            out_sof          <= 1'b0;
            octet_data       <= '0;
            octet_valid      <= 1'b0;
            frame_end        <= 1'b0;
            frame_runt       <= 1'b0;
            frame_abort      <= 1'b0;
            frame_misaligned <= 1'b0;
        end else begin
            out_bit          <= 1'b0;
            out_valid        <= 1'b0;
            out_sof          <= 1'b0;
            octet_data       <= '0;
            octet_valid      <= 1'b0;
            frame_end        <= 1'b0;
            frame_runt       <= 1'b0;
            frame_abort      <= 1'b0;
            frame_misaligned <= 1'b0;
            if (bit_en) begin
                if (emit) begin
                    out_bit   <= exit_s.val;
                    out_valid <= 1'b1;
                    out_sof   <= (cnt_q == '0);
                    cnt_q     <= cnt_inc;
                    pos_q     <= pos_inc;
                    sh_q      <= sh_next;
                    if (pos_q == POS_W'(OCTET_W - 1)) begin
                        octet_valid <= 1'b1;
                        octet_data  <= sh_next;
                    end
                end
                if (ev == EV_FLAG) begin
                    if (in_frame && cnt_inc != '0) begin
                        if (cnt_inc < CNT_W'(MIN_BITS)) begin
                            frame_runt <= 1'b1;
                        end else begin
                            frame_end        <= 1'b1;
                            frame_misaligned <= (pos_inc != '0);
                        end
                    end
                    in_frame <= 1'b1;
                    cnt_q    <= '0;
                    pos_q    <= '0;
                end else if (ev == EV_ABORT) begin
                    if (in_frame) frame_abort <= 1'b1;
                    in_frame <= 1'b0;
                    cnt_q    <= '0;
                    pos_q    <= '0;
                end
            end
        end
    end

    // R11
    strobe_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || frame_end || frame_runt || frame_abort) |-> $past(bit_en));
    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_end, frame_runt, frame_abort}));
    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        frame_abort |=> !out_valid);
    // R6
    end_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end || frame_runt) |=> !out_valid);
    // R10
    misalign_with_end_chk: assert property (@(posedge clk) disable iff (rst)
        frame_misaligned |-> frame_end);
    // R4
    sof_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);
    // R5
    octet_valid_chk: assert property (@(posedge clk) disable iff (rst)
        octet_valid |-> out_valid);

endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
    import hdlc_dfr_pkg::*;
#(
    parameter int MIN_BITS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       out_bit,
    output logic       out_valid,
    output logic       out_sof,
    output logic [7:0] octet_data,
    output logic       octet_valid,
    output logic       frame_end,
    output logic       frame_runt,
    output logic       frame_abort,
    output logic       frame_misaligned
);

    line_ev_e ev;
    slot_t    slot_in, slot_out;
    logic     in_frame;
    logic     flush;

    hdlc_run_tracker u_run (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .ev     (ev)
    );

    always_comb begin
        slot_in.val  = bit_in;
        slot_in.keep = in_frame && (ev == EV_DATA);
        flush        = (ev == EV_FLAG) || (ev == EV_ABORT);
    end

    hdlc_slot_line #(.DEPTH(FLAG_LEN)) u_line (
        .clk   (clk),
        .rst   (rst),
        .shift (bit_en),
        .flush (flush),
        .din   (slot_in),
        .dout  (slot_out)
    );

    hdlc_frame_tracker #(.MIN_BITS(MIN_BITS)) u_trk (
        .clk              (clk),
        .rst              (rst),
        .bit_en           (bit_en),
        .ev               (ev),
        .exit_s           (slot_out),
        .in_frame         (in_frame),
        .out_bit          (out_bit),
        .out_valid        (out_valid),
        .out_sof          (out_sof),
        .octet_data       (octet_data),
        .octet_valid      (octet_valid),
        .frame_end        (frame_end),
        .frame_runt       (frame_runt),
        .frame_abort      (frame_abort),
        .frame_misaligned (frame_misaligned)
    );

endmodule

// File: tb/hdlc_deframer_tb.sv
module hdlc_deframer_tb;

    localparam int MIN_BITS = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic out_bit, out_valid, out_sof, octet_valid;
    logic frame_end, frame_runt, frame_abort, frame_misaligned;
    logic [7:0] octet_data;

    hdlc_deframer #(.MIN_BITS(MIN_BITS)) u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .out_bit(out_bit), .out_valid(out_valid), .out_sof(out_sof),
        .octet_data(octet_data), .octet_valid(octet_valid),
        .frame_end(frame_end), .frame_runt(frame_runt),
        .frame_abort(frame_abort), .frame_misaligned(frame_misaligned)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int         m_ones = 0;
    bit         m_in = 1'b0;
    logic [1:0] m_q[$];
    int         m_cnt = 0;
    int         m_pos = 0;
    logic [7:0] m_sh = 8'h00;
    logic       e_bit, e_valid, e_sof, e_oval, e_end, e_runt, e_abort, e_mis;
    logic [7:0] e_oct;

    // tallies of observed outputs
    int n_end, n_runt, n_abort, n_mis, n_sof, n_bits;
    logic [7:0] got_oct[$];

    int tx_ones = 0;
    int gap_ctr = 0;

    task automatic check(input string req, input string name, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
        end
    endtask

    task automatic model(input logic en, input logic b);
        int prev;
        bit is_flag, is_stuff, is_abort, keep;
        logic [1:0] ex;
        e_bit = 0; e_valid = 0; e_sof = 0; e_oval = 0; e_oct = 8'h00;
        e_end = 0; e_runt = 0; e_abort = 0; e_mis = 0;
        if (!en) return;
        prev     = m_ones;
        is_flag  = !b && prev == 6;
        is_stuff = !b && prev == 5;
        is_abort = b && prev == 6;
        m_ones   = b ? ((m_ones < 7) ? m_ones + 1 : 7) : 0;
        keep     = m_in && !is_flag && !is_stuff && !is_abort;
        m_q.push_back({keep, b});
        if (m_q.size() > 8) begin
            ex = m_q.pop_front();
            if (ex[1] && !is_abort) begin
                e_bit   = ex[0];
                e_valid = 1;
                e_sof   = (m_cnt == 0);
                m_cnt++;
                m_sh = {ex[0], m_sh[7:1]};
                m_pos++;
                if (m_pos == 8) begin
                    e_oval = 1;
                    e_oct  = m_sh;
                    m_pos  = 0;
                end
            end
        end
        if (is_flag) begin
            if (m_in && m_cnt > 0) begin
                if (m_cnt < MIN_BITS) e_runt = 1;
                else begin
                    e_end = 1;
                    e_mis = (m_cnt % 8) != 0;
                end
            end
            m_q.delete();
            m_in = 1; m_cnt = 0; m_pos = 0;
        end else if (is_abort) begin
            if (m_in) e_abort = 1;
            m_q.delete();
            m_in = 0; m_cnt = 0; m_pos = 0;
        end
    endtask

    task automatic step(input logic en, input logic b);
        string tg;
        @(negedge clk);
        bit_en = en;
        bit_in = b;
        model(en, b);
        @(posedge clk);
        #1;
        if (!en) begin
            // R11: nothing may appear after an unqualified cycle
            check("R11", "out_valid", {7'd0, out_valid}, 8'h00);
            check("R11", "strobes", {4'd0, frame_end, frame_runt, frame_abort, octet_valid}, 8'h00);
        end else begin
            tg = "R2";
            check(tg, "out_valid", {7'd0, out_valid}, {7'd0, e_valid});
            check(tg, "out_bit", {7'd0, out_bit}, {7'd0, e_bit});
            check("R4", "out_sof", {7'd0, out_sof}, {7'd0, e_sof});
            check("R5", "octet_valid", {7'd0, octet_valid}, {7'd0, e_oval});
            check("R5", "octet_data", octet_data, e_oct);
            check("R6", "frame_end", {7'd0, frame_end}, {7'd0, e_end});
            check("R7", "frame_runt", {7'd0, frame_runt}, {7'd0, e_runt});
            check("R9", "frame_abort", {7'd0, frame_abort}, {7'd0, e_abort});
            check("R10", "frame_misaligned", {7'd0, frame_misaligned}, {7'd0, e_mis});
        end
        if (out_valid) n_bits++;
        if (out_sof) n_sof++;
        if (frame_end) n_end++;
        if (frame_runt) n_runt++;
        if (frame_abort) n_abort++;
        if (frame_misaligned) n_mis++;
        if (octet_valid) got_oct.push_back(octet_data);
    endtask

    task automatic line_bit(input logic b);
        gap_ctr++;
        if (gap_ctr % 7 == 0) step(1'b0, 1'b1);
        step(1'b1, b);
    endtask

    task automatic tx_data(input logic b);
        line_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                line_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_data(v[i]);
    endtask

    task automatic tx_flag();
        logic [7:0] f;
        f = 8'b0111_1110;
        for (int i = 7; i >= 0; i--) line_bit(f[i]);
        tx_ones = 0;
    endtask

    task automatic clear_tally();
        n_end = 0; n_runt = 0; n_abort = 0; n_mis = 0; n_sof = 0; n_bits = 0;
        got_oct.delete();
    endtask

    task automatic expect_tally(input string req, input int ends, input int runts, input int aborts,
                                input int mis, input int sofs, input int bits);
        check(req, "end count", 8'(n_end), 8'(ends));
        check(req, "runt count", 8'(n_runt), 8'(runts));
        check(req, "abort count", 8'(n_abort), 8'(aborts));
        check(req, "misaligned count", 8'(n_mis), 8'(mis));
        check(req, "sof count", 8'(n_sof), 8'(sofs));
        if (bits >= 0) check(req, "bit count", 8'(n_bits), 8'(bits));
    endtask

    task automatic expect_octets(input string req, input logic [7:0] a, input logic [7:0] b2,
                                 input logic [7:0] c, input logic [7:0] d);
        logic [7:0] exp_arr[4];
        exp_arr = '{a, b2, c, d};
        check(req, "octet count", 8'(got_oct.size()), 8'd4);
        for (int i = 0; i < 4; i++) begin
            if (i < got_oct.size()) check(req, "octet value", got_oct[i], exp_arr[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_tally();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "reset outputs",
              {out_bit, out_valid, out_sof, octet_valid, frame_end, frame_runt, frame_abort, frame_misaligned},
              8'h00);
        check("R1", "reset octet", octet_data, 8'h00);

        // R1 / R9: long run of ones while hunting gives nothing
        for (int i = 0; i < 12; i++) line_bit(1'b1);
        line_bit(1'b0);
        expect_tally("R9", 0, 0, 0, 0, 0, 0);

        // R3 / R5 / R6: heavily stuffed 32-bit frame
        clear_tally();
        tx_flag();
        tx_byte(8'hFF); tx_byte(8'h7E); tx_byte(8'h3C); tx_byte(8'hF8);
        tx_flag();
        expect_tally("R3", 1, 0, 0, 0, 1, 32);
        expect_octets("R5", 8'hFF, 8'h7E, 8'h3C, 8'hF8);

        // R6 / R7: shared flag opens a 24-bit runt
        clear_tally();
        tx_byte(8'h01); tx_byte(8'hFF); tx_byte(8'h80);
        tx_flag();
        expect_tally("R7", 0, 1, 0, 0, 1, 24);

        // R8: empty frames between adjacent flags
        clear_tally();
        tx_flag();
        tx_flag();
        expect_tally("R8", 0, 0, 0, 0, 0, 0);

        // R10: 35-bit frame
        clear_tally();
        tx_byte(8'h55); tx_byte(8'hC3); tx_byte(8'hFF); tx_byte(8'h0F);
        tx_data(1'b1); tx_data(1'b0); tx_data(1'b1);
        tx_flag();
        expect_tally("R10", 1, 0, 0, 1, 1, 35);
        expect_octets("R10", 8'h55, 8'hC3, 8'hFF, 8'h0F);

        // R7 boundary: 31 content bits
        clear_tally();
        tx_byte(8'h12); tx_byte(8'h34); tx_byte(8'h56);
        for (int i = 0; i < 7; i++) tx_data(1'b1);
        tx_flag();
        expect_tally("R7", 0, 1, 0, 0, 1, 31);

        // R9: abort inside a frame, then ones while hunting
        clear_tally();
        tx_byte(8'hA5); tx_byte(8'h5A);
        for (int i = 0; i < 8; i++) line_bit(1'b1);
        for (int i = 0; i < 10; i++) line_bit(1'b1);
        tx_ones = 0;
        expect_tally("R9", 0, 0, 1, 0, 1, -1);

        // R2 / R6: recovery after abort
        clear_tally();
        tx_flag();
        tx_byte(8'hAA); tx_byte(8'h0F); tx_byte(8'hF0); tx_byte(8'h81);
        tx_flag();
        expect_tally("R2", 1, 0, 0, 0, 1, 32);
        expect_octets("R6", 8'hAA, 8'h0F, 8'hF0, 8'h81);

        // R11: idle cycles afterwards
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule